// File: doc/BRIEF.md
# Prioritised Core Event Controller

This block arbitrates among sixteen event levels for a processor core. A request on one of the event inputs is accepted only when its level is enabled, either by the mask register or because the level is one of the five lowest, which cannot be masked. Accepted requests are held in a latch register until serviced. When events are globally allowed, the controller picks the lowest-numbered latched level. If that level is not already in service, it moves the level from latched to pending and emits a one-cycle take pulse. The pulse carries the level number and that level's target address from a sixteen-entry vector table.

Bit 4 of the pending register acts as the global-disable flag. Every take sets it, so a handler runs with events blocked until it issues the enable operation. A return input retires the active level. Software reaches the vector table, the mask, the latch and the pending register through a simple register port. Two single-cycle operations act on the mask: one saves it and forces it down to the unmaskable set, and one restores it. An exception indication accompanies a take at level 3, so that the core can save its return address in a separate register.

Sequencing is a three-state machine. ST_OPEN means events are allowed. ST_TAKEN lasts one cycle after a take. ST_GATED means global disable is set. The transitions are:

- ST_OPEN to ST_TAKEN on a take.
- ST_TAKEN to ST_GATED, or to ST_OPEN if the enable operation arrives in that cycle.
- ST_GATED to ST_OPEN when bit 4 clears, through the enable operation or a return.
- ST_OPEN to ST_TAKEN again, directly, when the next event is taken.

Top module: `evc_top`

## Requirements
- R1: After reset, the latch, pending and mask registers and all vector entries read zero, take_pulse is low and pend_idle is high. The register addresses are 0–15 for vectors, 16 for the mask, 17 for the latch and 18 for pending.
- R2: A request at level n sets latch bit n only when n < 5 or mask bit n is 1. Otherwise the request is dropped.
- R3: When events are allowed, the lowest-numbered latched level n is taken in the cycle after it becomes visible in the latch. A take produces a one-cycle take_pulse with take_level = n and take_target = vector entry n. It clears latch bit n and sets pending bit n.
- R4: Every take also sets pending bit 4. While bit 4 is set, no event is taken. The gint_enable operation clears bit 4.
- R5: When the lowest-numbered latched level already has its pending bit set, nothing is taken, including any higher-numbered latched level.
- R6: evt_return clears the lowest-numbered set pending bit among levels 1–15. Pending bit 0 is never cleared by a return.
- R7: pend_idle is high exactly when the pending register is all zero.
- R8: mask_disable copies the mask into saved_mask and sets the mask to 0x001F. mask_restore loads restore_val into the mask.
- R9: A register write to the latch clears each latch bit where a 1 is written. Writes to the pending register have no effect.
- R10: take_exc is high together with take_pulse exactly when the taken level is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 16 | Event request, one bit per level |
| evt_return | input | 1 | Retire the active level |
| gint_enable | input | 1 | Clear global disable (pending bit 4) |
| mask_disable | input | 1 | Save the mask and force it to 0x001F |
| mask_restore | input | 1 | Load restore_val into the mask |
| restore_val | input | 16 | Value for mask_restore |
| saved_mask | output | 16 | Mask captured by the last mask_disable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| take_pulse | output | 1 | One-cycle take indication |
| take_level | output | 4 | Level taken |
| take_target | output | 32 | Vector entry of the taken level |
| take_exc | output | 1 | Taken level is the exception level |
| pend_idle | output | 1 | Pending register is zero |

## Verification
The hardest case to reach is the stall where the winning latched level is already in service while a lower-priority level waits behind it. Reaching it takes a deliberate sequence. The stimulus first takes level 3, then re-enables events and raises level 3 again together with an unmasked level 7, and confirms that no take follows. It then retires level 3 and expects level 3 to win ahead of level 7. Latch write-one-to-clear is exercised in a similar way. The bench takes one event first, so that global disable holds requests in the latch where bus writes can reach them.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [1:0] {
        ST_OPEN,
        ST_TAKEN,
        ST_GATED
    } evc_state_e;

    localparam int OFS_MASK  = 0;
    localparam int OFS_LATCH = 1;
    localparam int OFS_PEND  = 2;
    localparam int NUM_CTRL  = 3;
endpackage

// File: rtl/evc_latch.sv
module evc_latch #(
    parameter int N     = 16,
    parameter int FIXED = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] take_clr_i,
    input  logic         w1c_en_i,
    input  logic [N-1:0] w1c_val_i,
    output logic [N-1:0] latch_o
);
    localparam logic [N-1:0] FIXED_MASK = N'((64'd1 << FIXED) - 64'd1);

    logic [N-1:0] eff_mask;
    logic [N-1:0] latch_q;
    logic [N-1:0] clr_bus;

    assign eff_mask = mask_i | FIXED_MASK;
    assign clr_bus  = w1c_en_i ? w1c_val_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= (latch_q & ~take_clr_i & ~clr_bus) | (req_i & eff_mask);
        end
    end

    assign latch_o = latch_q;

    // A latch bit may only rise because of an accepted request
    assert_latch_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q & ~$past(latch_q) & ~$past(req_i & eff_mask)) == '0))
        else $error("latch bit rose without accepted request");
endmodule

// File: rtl/evc_arbiter.sv
module evc_arbiter #(
    parameter int N     = 16,
    parameter int LVL_W = 4
) (
    input  logic [N-1:0]     latch_i,
    output logic [N-1:0]     grant_o,
    output logic [LVL_W-1:0] win_lvl_o,
    output logic             any_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_prio
        assign grant_o[i]  = latch_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | latch_i[i];
    end

    assign any_o = seen[N];

    always_comb begin
        win_lvl_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant_o[i]) win_lvl_o = LVL_W'(i);
        end
    end

    always_comb begin
        assert_grant_onehot_R3: assert ($onehot0(grant_o))
            else $error("more than one level granted");
    end
endmodule

// File: rtl/evc_pending.sv
module evc_pending #(
    parameter int N = 16,
    parameter int G = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic [N-1:0] take_oh_i,
    input  logic         ret_i,
    input  logic         gen_i,
    output logic [N-1:0] pend_o,
    output logic         gdis_nxt_o,
    output logic         idle_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;
    logic [N-1:0] rclr;
    logic [N-1:0] rseen;

    assign rclr[0]  = 1'b0;
    assign rseen[0] = 1'b0;
    assign rseen[1] = 1'b0;

    for (genvar i = 1; i < N; i++) begin : g_ret
        assign rclr[i] = pend_q[i] & ~rseen[i];
        if (i < N - 1) begin : g_chain
            assign rseen[i+1] = rseen[i] | pend_q[i];
        end
    end

    always_comb begin
        pend_d = pend_q & ~(ret_i ? rclr : '0);
        if (gen_i) pend_d[G] = 1'b0;
        if (take_i) begin
            pend_d    = pend_d | take_oh_i;
            pend_d[G] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o     = pend_q;
    assign gdis_nxt_o = pend_d[G];
    assign idle_o     = ~|pend_q;

    // Pending only empties through a return or the enable operation
    assert_idle_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(ret_i || gen_i))
        else $error("pending emptied without return or enable");

    // A return with no take never grows the pending set
    assert_ret_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !take_i) |=> ($countones(pend_q) <= $countones($past(pend_q))))
        else $error("return grew pending set");
endmodule

// File: rtl/evc_top.sv
module evc_top #(
    parameter int NUM_LVL    = 16,
    parameter int VEC_W      = 32,
    parameter int FIXED_LVLS = 5,
    parameter int GDIS_LVL   = 4,
    parameter int EXC_LVL    = 3,
    localparam int LVL_W     = $clog2(NUM_LVL),
    localparam int ADDR_W    = $clog2(NUM_LVL + evc_pkg::NUM_CTRL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] evt_req,
    input  logic               evt_return,
    input  logic               gint_enable,
    input  logic               mask_disable,
    input  logic               mask_restore,
    input  logic [NUM_LVL-1:0] restore_val,
    output logic [NUM_LVL-1:0] saved_mask,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [VEC_W-1:0]   reg_wdata,
    output logic [VEC_W-1:0]   reg_rdata,
    output logic               take_pulse,
    output logic [LVL_W-1:0]   take_level,
    output logic [VEC_W-1:0]   take_target,
    output logic               take_exc,
    output logic               pend_idle
);
    import evc_pkg::*;

    localparam logic [ADDR_W-1:0]  A_MASK  = ADDR_W'(NUM_LVL + OFS_MASK);
    localparam logic [ADDR_W-1:0]  A_LATCH = ADDR_W'(NUM_LVL + OFS_LATCH);
    localparam logic [ADDR_W-1:0]  A_PEND  = ADDR_W'(NUM_LVL + OFS_PEND);
    localparam logic [NUM_LVL-1:0] FIXED_MASK = NUM_LVL'((64'd1 << FIXED_LVLS) - 64'd1);

    evc_state_e         state_q, state_d;
    logic [VEC_W-1:0]   vec_q [NUM_LVL];
    logic [NUM_LVL-1:0] mask_q;
    logic [NUM_LVL-1:0] save_q;
    logic [NUM_LVL-1:0] latch_w;
    logic [NUM_LVL-1:0] grant_w;
    logic [NUM_LVL-1:0] pend_w;
    logic [LVL_W-1:0]   win_w;
    logic               any_w;
    logic               gdis_nxt_w;
    logic               take_now;
    logic               pulse_r;
    logic [LVL_W-1:0]   lvl_q;
    logic [VEC_W-1:0]   tgt_q;
    logic               exc_q;
    logic               in_vec;

    assign in_vec = (reg_addr < ADDR_W'(NUM_LVL));

    // Take when globally enabled, something latched, winner not in service
    assign take_now = !pend_w[GDIS_LVL] && any_w && ((grant_w & pend_w) == '0);

    evc_latch #(.N(NUM_LVL), .FIXED(FIXED_LVLS)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (evt_req),
        .mask_i     (mask_q),
        .take_clr_i (take_now ? grant_w : '0),
        .w1c_en_i   (reg_wr && (reg_addr == A_LATCH)),
        .w1c_val_i  (reg_wdata[NUM_LVL-1:0]),
        .latch_o    (latch_w)
    );

    evc_arbiter #(.N(NUM_LVL), .LVL_W(LVL_W)) u_arb (
        .latch_i   (latch_w),
        .grant_o   (grant_w),
        .win_lvl_o (win_w),
        .any_o     (any_w)
    );

    evc_pending #(.N(NUM_LVL), .G(GDIS_LVL)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take_now),
        .take_oh_i  (grant_w),
        .ret_i      (evt_return),
        .gen_i      (gint_enable),
        .pend_o     (pend_w),
        .gdis_nxt_o (gdis_nxt_w),
        .idle_o     (pend_idle)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN, ST_TAKEN, ST_GATED: begin
                if (take_now)        state_d = ST_TAKEN;
                else if (gdis_nxt_w) state_d = ST_GATED;
                else                 state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_TAKEN: pulse_r = 1'b1;
            default:  pulse_r = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            tgt_q <= '0;
            exc_q <= 1'b0;
        end else if (take_now) begin
            lvl_q <= win_w;
            tgt_q <= vec_q[win_w];
            exc_q <= (win_w == LVL_W'(EXC_LVL));
        end
    end

    assign take_pulse  = pulse_r;
    assign take_level  = lvl_q;
    assign take_target = tgt_q;
    assign take_exc    = pulse_r && exc_q;

    // Vector table
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_vec
        always_ff @(posedge clk) begin
            if (!rst_n) vec_q[i] <= '0;
            else if (reg_wr && (reg_addr == ADDR_W'(i))) vec_q[i] <= reg_wdata;
        end
    end

    // Mask with disable / restore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            save_q <= '0;
        end else if (mask_disable) begin
            save_q <= mask_q;
            mask_q <= FIXED_MASK;
        end else if (mask_restore) begin
            mask_q <= restore_val;
        end else if (reg_wr && (reg_addr == A_MASK)) begin
            mask_q <= reg_wdata[NUM_LVL-1:0];
        end
    end

    assign saved_mask = save_q;

    always_comb begin
        reg_rdata = '0;
        if (in_vec)                  reg_rdata = vec_q[reg_addr[LVL_W-1:0]];
        else if (reg_addr == A_MASK)  reg_rdata[NUM_LVL-1:0] = mask_q;
        else if (reg_addr == A_LATCH) reg_rdata[NUM_LVL-1:0] = latch_w;
        else if (reg_addr == A_PEND)  reg_rdata[NUM_LVL-1:0] = pend_w;
    end

    assert_take_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> pend_w[take_level])
        else $error("taken level not pending");

    assert_take_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> pend_w[GDIS_LVL])
        else $error("take without global disable");

    assert_gated_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w[GDIS_LVL] |=> !take_pulse)
        else $error("take while globally disabled");

    assert_disable_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_disable |=> (mask_q == FIXED_MASK && save_q == $past(mask_q)))
        else $error("mask disable wrong");

    assert_exc_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> (take_exc == (take_level == LVL_W'(EXC_LVL))))
        else $error("exception flag mismatch");

    assert_state_gdis_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATED) |-> pend_w[GDIS_LVL])
        else $error("gated state without disable bit");
endmodule

// File: tb/evc_top_tb_top.sv
module evc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_req = '0;
    logic        evt_return = 1'b0;
    logic        gint_enable = 1'b0;
    logic        mask_disable = 1'b0;
    logic        mask_restore = 1'b0;
    logic [15:0] restore_val = '0;
    logic [15:0] saved_mask;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take_pulse;
    logic [3:0]  take_level;
    logic [31:0] take_target;
    logic        take_exc;
    logic        pend_idle;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [3:0]  lvl;
        logic [31:0] tgt;
        logic        exc;
    } take_t;
    take_t exp_q[$];

    always #2 clk = ~clk;

    evc_top dut_i (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .evt_return(evt_return),
        .gint_enable(gint_enable), .mask_disable(mask_disable),
        .mask_restore(mask_restore), .restore_val(restore_val),
        .saved_mask(saved_mask), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take_pulse(take_pulse),
        .take_level(take_level), .take_target(take_target), .take_exc(take_exc),
        .pend_idle(pend_idle)
    );

    function automatic logic [31:0] vtgt(input int l);
        return 32'h0000_1000 + 32'(l) * 32'h40;
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 5'(a);
        #1;
        check(reg_rdata, exp, tag);
    endtask

    task automatic req(input logic [15:0] v);
        evt_req = v; tick(); evt_req = '0;
    endtask

    task automatic ret();
        evt_return = 1'b1; tick(); evt_return = 1'b0;
    endtask

    task automatic gen();
        gint_enable = 1'b1; tick(); gint_enable = 1'b0;
    endtask

    task automatic expect_take(input int l);
        take_t t;
        t.lvl = 4'(l); t.tgt = vtgt(l); t.exc = (l == 3);
        exp_q.push_back(t);
    endtask

    // Monitor / scoreboard (R3, R10)
    always @(negedge clk) begin
        if (rst_n && take_pulse) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R3/R4/R5: unexpected take level %0d expected none", take_level);
            end else begin
                take_t e;
                e = exp_q.pop_front();
                check({28'd0, take_level}, {28'd0, e.lvl}, "R3 take_level");
                check(take_target, e.tgt, "R3 take_target");
                check({31'd0, take_exc}, {31'd0, e.exc}, "R10 take_exc");
            end
        end
    end

    initial begin
        #150000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd_chk(17, 0, "R1 latch");
        rd_chk(18, 0, "R1 pend");
        rd_chk(16, 0, "R1 mask");
        rd_chk(5, 0, "R1 vector");
        check({31'd0, pend_idle}, 1, "R1 idle");
        check({31'd0, take_pulse}, 0, "R1 take_pulse");

        for (int i = 0; i < 16; i++) wr(i, vtgt(i));
        rd_chk(5, vtgt(5), "R3 vector readback");

        // R2 masked level dropped
        req(16'h0200);
        tick();
        rd_chk(17, 0, "R2 masked drop");

        // R3/R4 basic take of level 6
        wr(16, 32'h0040);
        expect_take(6);
        req(16'h0040);
        tick(); tick();
        rd_chk(18, 32'h0050, "R4 pend after take");
        check({31'd0, pend_idle}, 0, "R7 idle low");

        // R2/R4 unmaskable level latched but held while gated
        req(16'h0004);
        tick(); tick();
        rd_chk(17, 32'h0004, "R2 unmaskable latched");
        expect_take(2);
        gen();
        tick(); tick();
        rd_chk(18, 32'h0054, "R4 take after enable");

        // R6 return order
        ret(); rd_chk(18, 32'h0050, "R6 ret clears 2");
        ret(); rd_chk(18, 32'h0040, "R6 ret clears 4");
        ret(); rd_chk(18, 32'h0000, "R6 ret clears 6");
        check({31'd0, pend_idle}, 1, "R7 idle high");

        // R5 winner already in service; R10 exception level
        wr(16, 32'h0080);
        expect_take(3);
        req(16'h0008);
        tick(); tick();
        rd_chk(18, 32'h0018, "R10 pend after exc take");
        gen();
        rd_chk(18, 32'h0008, "R4 enable clears bit4");
        req(16'h0088);
        tick(); tick(); tick();
        rd_chk(17, 32'h0088, "R5 stall holds latch");
        expect_take(3);
        ret();
        tick(); tick();
        rd_chk(18, 32'h0018, "R5 retaken after retire");
        expect_take(7);
        gen();
        tick(); tick();
        rd_chk(18, 32'h0098, "R5 lower level follows");
        ret(); rd_chk(18, 32'h0090, "R6 nested ret");
        ret(); ret();
        rd_chk(18, 0, "R6 drained");

        // R9 latch W1C, pending read-only
        expect_take(1);
        req(16'h0002);
        tick(); tick();
        rd_chk(18, 32'h0012, "R9 setup pend");
        req(16'h0006);
        tick();
        rd_chk(17, 32'h0006, "R9 latch before clear");
        wr(17, 32'h0002);
        rd_chk(17, 32'h0004, "R9 w1c one bit");
        wr(18, 32'hFFFF);
        rd_chk(18, 32'h0012, "R9 pend write ignored");
        wr(17, 32'h0004);
        rd_chk(17, 0, "R9 w1c second");
        ret(); ret();
        rd_chk(18, 0, "R9 cleanup");

        // R8 disable / restore
        wr(16, 32'h0A55);
        mask_disable = 1'b1; tick(); mask_disable = 1'b0;
        check({16'd0, saved_mask}, 32'h0A55, "R8 saved mask");
        rd_chk(16, 32'h001F, "R8 mask forced");
        restore_val = 16'h1234;
        mask_restore = 1'b1; tick(); mask_restore = 1'b0;
        rd_chk(16, 32'h1234, "R8 restore");

        // R3 priority among simultaneous requests
        wr(16, 32'h0120);
        expect_take(5);
        req(16'h0120);
        tick(); tick();
        rd_chk(17, 32'h0100, "R3 lower level waits");
        expect_take(8);
        gen();
        tick(); tick();
        rd_chk(18, 32'h0130, "R3 second take");
        ret(); ret(); ret();
        rd_chk(18, 0, "R6 drained again");

        // R6 level 0 never retired
        expect_take(0);
        req(16'h0001);
        tick(); tick();
        gen();
        ret();
        rd_chk(18, 32'h0001, "R6 bit0 kept");
        check({31'd0, pend_idle}, 0, "R7 idle with bit0");

        tick(); tick();
        check(32'(exp_q.size()), 0, "R3 all expected takes seen");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule